// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block receives asynchronous serial characters on a single line. The line is first passed through a two-flop synchronizer. It is then sampled once per pulse of a tick enable that runs at sixteen times the bit rate, so each bit period holds sixteen sample slots, numbered 1 to 16. The value of each bit is the majority of three samples taken at its centre.

The slot counter is realigned when a start bit is detected. It is realigned again when one data bit decides to 1 and the next decides to 0. In that case the slot is recomputed from the time that has passed since the falling edge was observed. This keeps the centre samples aligned when the transmitter's bit rate differs somewhat from the receiver's.

Each completed character is placed in a one-entry output buffer.

- The buffer offers the character on a valid/ready stream port.
- `out_valid` is the receiver-full flag.
- A transfer happens on any clock edge where `out_valid` and `out_ready` are both high. The transfer empties the buffer.
- Back-pressure is absorbed by the buffer. While the buffer is full and not being read, a newly completed character is dropped, the buffer keeps its content, and the overrun flag is raised.
- If a character completes in the same cycle as a transfer, the new character is loaded and no overrun is flagged.
- An interrupt request follows the full flag, gated by an enable input.

Top module: `rxo_top`

## Requirements
- R1: A frame is an idle-high line, one start bit of 0, eight data bits with the least significant bit first, and one stop bit. The eight data bits appear on `out_data` with bit 0 being the first one received.
- R2: The line is sampled once per `tick16` pulse. Each data bit takes the majority of its samples in slots 8, 9 and 10 of its sixteen-slot period, so a single wrong sample near the bit centre does not change the received bit.
- R3: A start is detected only when a 0 sample follows at least three consecutive 1 samples. The start is kept only if at least two of the samples in slots 3, 5 and 7 are 0. Otherwise the receiver returns to idle and delivers nothing.
- R4: The slot counter is realigned at each start bit. It is also realigned whenever a data bit decided 1 is followed by a data bit decided 0, using the observed falling edge. With this, characters whose bits last 15 or 17 ticks are still received correctly.
- R5: When a character completes, its data is loaded into the buffer and `out_valid` rises within two clock cycles after the tick that decides the stop bit. After reset `out_valid`, `frame_err`, `overrun` and `irq` are 0.
- R6: `irq` is high exactly when `out_valid` and `irq_en` are both high.
- R7: A transfer (`out_valid` and `out_ready` high at a clock edge) clears `out_valid` on that edge, unless a new character completes in the same cycle.
- R8: If the stop bit decides 0, `frame_err` is set along with loading the data byte. `frame_err` always describes the character currently held in the buffer.
- R9: A character that completes while the buffer is full and not being read sets `overrun` and leaves `out_data` unchanged. A transfer clears `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable, one pulse per sixteenth of a bit |
| rxd | input | 1 | Serial receive line, idle high |
| irq_en | input | 1 | Receive interrupt enable |
| out_ready | input | 1 | Consumer ready, completes a transfer together with out_valid |
| out_valid | output | 1 | Buffer holds an unread character (receiver-full flag) |
| out_data | output | 8 | Buffered character |
| frame_err | output | 1 | Buffered character had a 0 stop bit |
| overrun | output | 1 | A character was lost while the buffer was full |
| irq | output | 1 | Interrupt request |

## Verification
Random bytes at the nominal sixteen ticks per bit check the bit order and the buffer path.

Bytes with many alternating bits, sent at fifteen and seventeen ticks per bit, separate a receiver that realigns on data falling edges from one that only aligns at the start bit. Without the realignment, the later bits drift out of their windows.

Three further patterns each target one feature:
- A single flipped tick inside a bit checks the three-sample vote.
- A two-tick low pulse checks that a false start is rejected.
- A zero stop bit, and two characters received without a read in between, separate the framing-error path from the overrun path.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/rxo_sync.sv
module rxo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxo_core.sv
module rxo_core
  import rxo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              din,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              stop_bad
);
  localparam int SW = $clog2(OVS + 1);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int MID = OVS / 2;
  localparam logic [SW-1:0] S_MID0 = SW'(MID);
  localparam logic [SW-1:0] S_MID1 = SW'(MID + 1);
  localparam logic [SW-1:0] S_MID2 = SW'(MID + 2);
  localparam logic [SW-1:0] S_V0   = SW'(MID - 5);
  localparam logic [SW-1:0] S_V1   = SW'(MID - 3);
  localparam logic [SW-1:0] S_V2   = SW'(MID - 1);
  localparam logic [SW-1:0] S_LAST = SW'(OVS - 1);
  localparam logic [SW-1:0] S_FULL = SW'(OVS);
  localparam logic [BW-1:0] B_LAST = BW'(DATA_W - 1);

  rx_state_e         state;
  logic [SW-1:0]     slot, age;
  logic [SW-1:0]     cur_slot, cur_age, resync_slot;
  logic [1:0]        ones, vote, sv;
  logic [BW-1:0]     bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              bit_done, prev_bit, prev_smp, edge_seen;
  logic              mid_maj, st_maj, fall;

  always_comb begin
    cur_slot    = slot + 1'b1;
    cur_age     = (age == S_FULL) ? age : age + 1'b1;
    resync_slot = (cur_age > S_LAST) ? S_LAST : cur_age;
    mid_maj     = maj3(vote[0], vote[1], din);
    st_maj      = maj3(sv[0], sv[1], din);
    fall        = prev_smp & ~din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      slot      <= '0;
      age       <= '0;
      ones      <= '0;
      vote      <= '0;
      sv        <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      bit_done  <= 1'b0;
      prev_bit  <= 1'b0;
      prev_smp  <= 1'b1;
      edge_seen <= 1'b0;
      done      <= 1'b0;
      data      <= '0;
      stop_bad  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        prev_smp <= din;
        case (state)
          ST_IDLE: begin
            ones <= din ? ((ones == 2'd3) ? 2'd3 : ones + 2'd1) : 2'd0;
            if (!din && ones == 2'd3) begin
              state <= ST_START;
              slot  <= SW'(1);
            end
          end
          ST_START: begin
            slot <= cur_slot;
            if (cur_slot == S_V0) sv[0] <= din;
            if (cur_slot == S_V1) sv[1] <= din;
            if (cur_slot == S_V2 && st_maj) begin
              state <= ST_IDLE;
              ones  <= 2'd0;
            end
            if (cur_slot == S_FULL) begin
              state     <= ST_DATA;
              slot      <= '0;
              bit_idx   <= '0;
              bit_done  <= 1'b0;
              prev_bit  <= 1'b0;
              edge_seen <= 1'b0;
            end
          end
          default: begin
            slot <= cur_slot;
            if (fall && !edge_seen) begin
              edge_seen <= 1'b1;
              age       <= SW'(1);
            end else begin
              age <= cur_age;
            end
            if (cur_slot == S_MID0) vote[0] <= din;
            if (cur_slot == S_MID1) vote[1] <= din;
            if (cur_slot == S_MID2 && !bit_done) begin
              bit_done <= 1'b1;
              if (state == ST_DATA) begin
                shreg     <= {mid_maj, shreg[DATA_W-1:1]};
                prev_bit  <= mid_maj;
                edge_seen <= 1'b0;
                if (prev_bit && !mid_maj && edge_seen) slot <= resync_slot;
              end else begin
                done     <= 1'b1;
                data     <= shreg;
                stop_bad <= ~mid_maj;
                state    <= ST_IDLE;
                ones     <= 2'd0;
              end
            end
            if (cur_slot == S_FULL && state == ST_DATA) begin
              slot     <= '0;
              bit_done <= 1'b0;
              if (bit_idx == B_LAST) state <= ST_STOP;
              else                   bit_idx <= bit_idx + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rxo_buffer.sv
module rxo_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_ferr,
  input  logic              rd_ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              ferr,
  output logic              ovr
);
  logic take;
  assign take = valid & rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      ferr  <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      if (take) ovr <= 1'b0;
      if (load && (!valid || take)) begin
        valid <= 1'b1;
        data  <= load_data;
        ferr  <= load_ferr;
      end else if (load) begin
        ovr <= 1'b1;
      end else if (take) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxo_top.sv
module rxo_top #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              irq_en,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              frame_err,
  output logic              overrun,
  output logic              irq
);
  logic              rx_s;
  logic              char_done;
  logic [DATA_W-1:0] char_data;
  logic              char_ferr;

  rxo_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
  );

  rxo_core #(.DATA_W(DATA_W), .OVS(OVS)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .din(rx_s),
    .done(char_done), .data(char_data), .stop_bad(char_ferr)
  );

  rxo_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(char_done), .load_data(char_data),
    .load_ferr(char_ferr), .rd_ready(out_ready), .valid(out_valid),
    .data(out_data), .ferr(frame_err), .ovr(overrun)
  );

  assign irq = out_valid & irq_en;
endmodule

// File: rtl/rxo_chk.sv
module rxo_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_en,
  input logic              out_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              overrun,
  input logic              irq,
  input logic              char_done
);
  AST_IRQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (out_valid && irq_en)); // R6
  AST_IRQ_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && irq_en) |-> irq); // R6
  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> out_valid); // R5
  AST_NO_SPURIOUS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !char_done) |=> !out_valid); // R5
  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !char_done) |=> !out_valid); // R7
  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && char_done) |=> (overrun && $stable(out_data))); // R9
  AST_OVERRUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !overrun); // R9
endmodule

bind rxo_top rxo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .out_ready(out_ready),
  .out_valid(out_valid), .out_data(out_data), .overrun(overrun),
  .irq(irq), .char_done(char_done)
);

// File: tb/test_rxo_top.sv
module test_rxo_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16;
  logic       rxd = 1'b1;
  logic       irq_en = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid, frame_err, overrun, irq;
  logic [7:0] out_data;
  logic [1:0] tcnt;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tcnt + 2'd1;
  end
  assign tick16 = (tcnt == 2'd0);

  rxo_top i_rxo_top (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .irq_en(irq_en),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .frame_err(frame_err), .overrun(overrun), .irq(irq)
  );

  function automatic logic exp_irq(input logic v, input logic en);
    return v & en;
  endfunction

  function automatic logic frame_bit(input logic [7:0] d, input logic stp, input int i);
    if (i == 0) return 1'b0;
    if (i == 9) return stp;
    return d[i-1];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do begin
      @(posedge clk);
      #1;
    end while (!tick16);
  endtask

  task automatic idle_ticks(input int n);
    rxd = 1'b1;
    for (int k = 0; k < n; k++) wait_tick();
  endtask

  // glitch_bit: frame bit index (0 start .. 9 stop) that gets one flipped tick, -1 none
  task automatic send_frame(input logic [7:0] d, input logic stp, input int tpb, input int glitch_bit);
    for (int i = 0; i < 10; i++) begin
      for (int t = 0; t < tpb; t++) begin
        rxd = (i == glitch_bit && t == tpb / 2) ? ~frame_bit(d, stp, i) : frame_bit(d, stp, i);
        wait_tick();
      end
    end
    idle_ticks(6);
    @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic rx_and_check(input string req, input logic [7:0] d, input int tpb);
    send_frame(d, 1'b1, tpb, -1);
    check({req, " valid"}, out_valid, 1'b1);
    check({req, " data"}, out_data, d);
    check({req, " frame_err"}, frame_err, 1'b0);
    do_read();
    idle_ticks(4);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    check("R5 reset valid", out_valid, 1'b0);
    check("R8 reset frame_err", frame_err, 1'b0);
    check("R9 reset overrun", overrun, 1'b0);
    check("R6 reset irq", irq, 1'b0);
    idle_ticks(8);

    // R1 R5 R6 nominal character
    irq_en = 1'b1;
    send_frame(8'hA5, 1'b1, 16, -1);
    check("R5 valid after frame", out_valid, 1'b1);
    check("R1 data A5", out_data, 8'hA5);
    check("R6 irq enabled", irq, exp_irq(out_valid, irq_en));
    irq_en = 1'b0;
    #1;
    check("R6 irq masked", irq, 1'b0);
    irq_en = 1'b1;
    do_read();
    check("R7 valid cleared by read", out_valid, 1'b0);
    check("R6 irq after read", irq, 1'b0);
    idle_ticks(4);

    // R4 bit rate mismatch, realignment on data falling edges
    rx_and_check("R4 fast 55", 8'h55, 15);
    rx_and_check("R4 fast AA", 8'hAA, 15);
    rx_and_check("R4 slow 55", 8'h55, 17);
    rx_and_check("R4 slow 4D", 8'h4D, 17);

    // R8 framing error, byte still loaded
    send_frame(8'h3C, 1'b0, 16, -1);
    check("R8 frame_err set", frame_err, 1'b1);
    check("R8 data loaded", out_data, 8'h3C);
    check("R8 valid", out_valid, 1'b1);
    do_read();
    idle_ticks(4);

    // R9 overrun keeps first byte
    send_frame(8'h11, 1'b1, 16, -1);
    send_frame(8'h22, 1'b1, 16, -1);
    check("R9 overrun set", overrun, 1'b1);
    check("R9 data kept", out_data, 8'h11);
    check("R9 still valid", out_valid, 1'b1);
    do_read();
    check("R9 overrun cleared", overrun, 1'b0);
    check("R7 valid cleared", out_valid, 1'b0);
    idle_ticks(4);

    // R3 short low pulse is not a start
    rxd = 1'b0;
    wait_tick();
    wait_tick();
    idle_ticks(40);
    @(negedge clk);
    check("R3 false start ignored", out_valid, 1'b0);
    rx_and_check("R3 start after false", 8'hC3, 16);

    // R2 single flipped sample at bit centre
    send_frame(8'h00, 1'b1, 16, 4);
    check("R2 glitch in zero bit", out_data, 8'h00);
    do_read();
    idle_ticks(4);
    send_frame(8'hFF, 1'b1, 16, 6);
    check("R2 glitch in one bit", out_data, 8'hFF);
    do_read();
    idle_ticks(4);

    // R1 random bytes
    for (int n = 0; n < 12; n++) begin
      logic [7:0] b;
      b = 8'($urandom);
      rx_and_check("R1 random", b, 16);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule